// File: doc/BRIEF.md
# Reloading 12-bit Up-Counter with Input Capture

This block is a small bus-mapped timer. A 12-bit counter advances by one on each pulse of a chosen clock-enable input. When it is at its maximum count and steps again, it does not wrap to zero: it loads a value that software placed in a reload register. The wrap raises an overflow flag. A rising edge on an external capture pin, after two synchronising flip-flops, copies the counter into a pair of capture registers and raises a capture flag.

Both flags are cleared by the act of reading, not by writing. Reading the control/status byte clears the overflow flag. Reading either capture byte clears the capture flag. When a hardware set and a clearing read land in the same cycle, the set is kept. Two level interrupt outputs combine each flag with its enable. A third output exposes the compare-interrupt mask bit to a neighbouring compare unit. The bus is a single-cycle byte interface. Read data is combinational from the address, and the clearing side effects take place at the clock edge that ends the read strobe.

Top module: `artimer_cap`

## Requirements
- R1: After reset every register reads 0 at every address, and `ovf_irq`, `cap_irq` and `cmp_mask` are 0.
- R2: The counter increases by exactly one on each clock edge where the selected enable input is high. It holds its value otherwise, and it always holds while the select field is 00.
- R3: The select field, control bits 4:3, picks the enable source: 01 = `tick_base`, 10 = `tick_cpu`, 11 = `tick_fast`.
- R4: A step taken while the counter is 0xFFF loads the reload value into the counter instead of 0, and sets the overflow flag (control bit 2).
- R5: Address 0 reads {0, capture flag, capture enable, select[1:0], overflow flag, overflow enable, compare enable}. A read strobe at address 0 clears the overflow flag at that edge, unless an overflow occurs in the same cycle, in which case the flag stays set.
- R6: A write to address 0 updates bits 5, 4:3, 1 and 0. Bits 7, 6 and 2 are not changed by the written value.
- R7: Address 1 reads {4'b0, counter[11:8]} and address 2 reads counter[7:0]. Writes to either address have no effect on the counter.
- R8: The reload register resets to 0. A write to address 3 sets reload[11:8] from wdata[3:0], and a write to address 4 sets reload[7:0]. Both bytes read back at the same addresses.
- R9: A rising edge on `cap_pin` copies the counter into the capture register and sets the capture flag. The edge is seen after two synchronising flops, so the value copied is the one the counter holds just before the third clock edge after the pin rises. Address 5 reads {4'b0, capture[11:8]} and address 6 reads capture[7:0].
- R10: A read strobe at address 5 or 6 clears the capture flag, unless a capture occurs in the same cycle, in which case the flag stays set.
- R11: `ovf_irq` is overflow flag AND overflow enable, `cap_irq` is capture flag AND capture enable, and `cmp_mask` is control bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, triggers clear-on-read side effects |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cap_pin | input | 1 | Asynchronous capture input |
| tick_base | input | 1 | Timebase-tick clock enable |
| tick_cpu | input | 1 | CPU-rate clock enable |
| tick_fast | input | 1 | Fast clock enable |
| ovf_irq | output | 1 | Overflow interrupt level |
| cap_irq | output | 1 | Capture interrupt level |
| cmp_mask | output | 1 | Compare-interrupt enable bit |

## Verification
The bench builds the block with its default 12-bit counter. At that width a full count from zero to the first wrap takes about 8k cycles with the CPU enable at half rate, which is short enough to run within the bench. Loading a reload value just below the top (0xFF0, then 0xFFE) makes the counter wrap every few steps. That puts overflow events in the same cycle as back-to-back status reads, so the set-wins case is reached. Capture pulses arrive while the counter is moving, which tests that the copied value comes from the correct cycle after synchronisation.

// File: rtl/artimer_pkg.sv
package artimer_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLDH = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLDL = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAPH = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAPL = 3'd6;

  localparam int B_CAPF  = 6;
  localparam int B_CAPIE = 5;
  localparam int B_CKS   = 3;
  localparam int B_OVF   = 2;
  localparam int B_OVFIE = 1;
  localparam int B_CMPIE = 0;

  typedef enum logic [1:0] {
    CKS_OFF  = 2'b00,
    CKS_BASE = 2'b01,
    CKS_CPU  = 2'b10,
    CKS_FAST = 2'b11
  } cks_e;
endpackage

// File: rtl/artimer_sel.sv
module artimer_sel
  import artimer_pkg::*;
(
  input  cks_e sel,
  input  logic tick_base,
  input  logic tick_cpu,
  input  logic tick_fast,
  output logic step
);
  always_comb begin
    unique case (sel)
      CKS_BASE: step = tick_base;
      CKS_CPU:  step = tick_cpu;
      CKS_FAST: step = tick_fast;
      default:  step = 1'b0;
    endcase
  end
endmodule

// File: rtl/artimer_core.sv
module artimer_core #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] rld,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    wrap  = step && (cnt == CNT_MAX);
    cnt_d = cnt;
    if (wrap)      cnt_d = rld;
    else if (step) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == CNT_MAX) |=> cnt == $past(rld));
endmodule

// File: rtl/artimer_capt.sv
module artimer_capt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap,
  output logic             hit
);
  logic             s1, s2, s3;
  logic [CNT_W-1:0] cap_d;

  always_comb begin
    hit   = s2 && !s3;
    cap_d = hit ? cnt : cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      s3  <= 1'b0;
      cap <= '0;
    end else begin
      s1  <= pin;
      s2  <= s1;
      s3  <= s2;
      cap <= cap_d;
    end
  end

  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cap == $past(cnt));
  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cap));
endmodule

// File: rtl/artimer_cap.sv
module artimer_cap
  import artimer_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              cap_pin,
  input  logic              tick_base,
  input  logic              tick_cpu,
  input  logic              tick_fast,
  output logic              ovf_irq,
  output logic              cap_irq,
  output logic              cmp_mask
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [1:0]       rst_pipe;
  logic             rst_sn;
  cks_e             cks, cks_d;
  logic             capie, capie_d, ovfie, ovfie_d, cmpie, cmpie_d;
  logic             ovf_f, ovf_d, cap_f, cap_d;
  logic [CNT_W-1:0] rld, rld_d, cnt, cap;
  logic             step, wrap, hit;
  logic             wr_ctrl, rd_ctrl, rd_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  artimer_sel u_sel (
    .sel(cks), .tick_base(tick_base), .tick_cpu(tick_cpu),
    .tick_fast(tick_fast), .step(step)
  );

  artimer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_sn), .step(step), .rld(rld), .cnt(cnt), .wrap(wrap)
  );

  artimer_capt #(.CNT_W(CNT_W)) u_capt (
    .clk(clk), .rst_n(rst_sn), .pin(cap_pin), .cnt(cnt), .cap(cap), .hit(hit)
  );

  always_comb begin
    wr_ctrl = wr_en && (addr == A_CTRL);
    rd_ctrl = rd_en && (addr == A_CTRL);
    rd_cap  = rd_en && ((addr == A_CAPH) || (addr == A_CAPL));
    cks_d   = cks;
    capie_d = capie;
    ovfie_d = ovfie;
    cmpie_d = cmpie;
    rld_d   = rld;
    if (wr_ctrl) begin
      capie_d = wdata[B_CAPIE];
      cks_d   = cks_e'(wdata[B_CKS+1:B_CKS]);
      ovfie_d = wdata[B_OVFIE];
      cmpie_d = wdata[B_CMPIE];
    end
    if (wr_en && addr == A_RLDH) rld_d[CNT_W-1:DATA_W] = wdata[HI_W-1:0];
    if (wr_en && addr == A_RLDL) rld_d[DATA_W-1:0]     = wdata;
    // hardware set has priority over the clearing read
    ovf_d = wrap || (ovf_f && !rd_ctrl);
    cap_d = hit  || (cap_f && !rd_cap);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cks   <= CKS_OFF;
      capie <= 1'b0;
      ovfie <= 1'b0;
      cmpie <= 1'b0;
      ovf_f <= 1'b0;
      cap_f <= 1'b0;
      rld   <= '0;
    end else begin
      cks   <= cks_d;
      capie <= capie_d;
      ovfie <= ovfie_d;
      cmpie <= cmpie_d;
      ovf_f <= ovf_d;
      cap_f <= cap_d;
      rld   <= rld_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: rdata = {1'b0, cap_f, capie, cks, ovf_f, ovfie, cmpie};
      A_CNTH: rdata = DATA_W'(cnt[CNT_W-1:DATA_W]);
      A_CNTL: rdata = cnt[DATA_W-1:0];
      A_RLDH: rdata = DATA_W'(rld[CNT_W-1:DATA_W]);
      A_RLDL: rdata = rld[DATA_W-1:0];
      A_CAPH: rdata = DATA_W'(cap[CNT_W-1:DATA_W]);
      A_CAPL: rdata = cap[DATA_W-1:0];
      default: rdata = '0;
    endcase
  end

  assign ovf_irq  = ovf_f && ovfie;
  assign cap_irq  = cap_f && capie;
  assign cmp_mask = cmpie;

  p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    wrap |=> ovf_f);
  p_ovf_clr_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en && addr == A_CTRL && !wrap) |=> !ovf_f);
  p_flag_ro_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && addr == A_CTRL && !rd_en && !wrap && !hit)
      |=> (ovf_f == $past(ovf_f) && cap_f == $past(cap_f)));
  p_rld_keep_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    !(wr_en && (addr == A_RLDH || addr == A_RLDL)) |=> $stable(rld));
  p_cap_clr_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en && (addr == A_CAPH || addr == A_CAPL) && !hit) |=> !cap_f);
  p_cap_set_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    hit |=> cap_f);
endmodule

// File: tb/artimer_cap_tb_top.sv
module artimer_cap_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, cap_pin = 1'b0;
  logic       tick_base = 1'b0, tick_cpu = 1'b0, tick_fast = 1'b0;
  logic [7:0] rdata;
  logic       ovf_irq, cap_irq, cmp_mask;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  artimer_cap dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .cap_pin(cap_pin), .tick_base(tick_base),
    .tick_cpu(tick_cpu), .tick_fast(tick_fast), .ovf_irq(ovf_irq),
    .cap_irq(cap_irq), .cmp_mask(cmp_mask)
  );

  // enable pulse generator: fast every cycle, cpu every 2nd, base every 7th
  int tcount = 0;
  always @(posedge clk) begin
    #1;
    tcount++;
    tick_fast = 1'b1;
    tick_cpu  = (tcount % 2) == 0;
    tick_base = (tcount % 7) == 0;
  end

  // behavioural reference
  int m_cnt, m_rld, m_cap, m_cks;
  bit m_ovf, m_capf, m_capie, m_ovfie, m_cmpie;
  bit pin_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rld = 0; m_cap = 0; m_cks = 0;
      m_ovf = 0; m_capf = 0; m_capie = 0; m_ovfie = 0; m_cmpie = 0;
      pin_hist = '{0, 0, 0};
    end else begin
      bit stp, wr_ovf, edge_seen;
      stp = (m_cks == 1) ? tick_base : (m_cks == 2) ? tick_cpu :
            (m_cks == 3) ? tick_fast : 1'b0;
      wr_ovf = stp && (m_cnt == 4095);
      edge_seen = pin_hist[1] && !pin_hist[2];
      if (edge_seen) m_cap = m_cnt;
      if (wr_ovf) m_ovf = 1;
      else if (rd_en && addr == 0) m_ovf = 0;
      if (edge_seen) m_capf = 1;
      else if (rd_en && (addr == 5 || addr == 6)) m_capf = 0;
      if (wr_ovf) m_cnt = m_rld;
      else if (stp) m_cnt = m_cnt + 1;
      if (wr_en && addr == 0) begin
        m_capie = wdata[5]; m_cks = int'(wdata[4:3]);
        m_ovfie = wdata[1]; m_cmpie = wdata[0];
      end
      if (wr_en && addr == 3) m_rld = (m_rld & 255) | (int'(wdata[3:0]) << 8);
      if (wr_en && addr == 4) m_rld = (m_rld & 32'hF00) | int'(wdata);
      pin_hist.push_front(cap_pin);
      void'(pin_hist.pop_back());
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {1'b0, m_capf, m_capie, 2'(m_cks), m_ovf, m_ovfie, m_cmpie};
      3'd1: return 8'(m_cnt >> 8);
      3'd2: return 8'(m_cnt & 255);
      3'd3: return 8'(m_rld >> 8);
      3'd4: return 8'(m_rld & 255);
      3'd5: return 8'(m_cap >> 8);
      3'd6: return 8'(m_cap & 255);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R11: interrupt outputs compared on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 ovf_irq", int'(ovf_irq), int'(m_ovf && m_ovfie));
      chk("R11 cap_irq", int'(cap_irq), int'(m_capf && m_capie));
      chk("R11 cmp_mask", int'(cmp_mask), int'(m_cmpie));
    end
  end

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, input string req);
    @(posedge clk); #1;
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    chk(req, int'(rdata), int'(m_read(a)));
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic pulse_pin(input int hi_cycles);
    @(posedge clk); #1;
    cap_pin = 1'b1;
    repeat (hi_cycles) @(posedge clk);
    #1 cap_pin = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset state at every address
    for (int a = 0; a < 8; a++) begin
      @(posedge clk); #1 addr = 3'(a);
      @(negedge clk);
      chk("R1 reset read", int'(rdata), 0);
    end
    chk("R1 ovf_irq", int'(ovf_irq), 0);
    chk("R1 cap_irq", int'(cap_irq), 0);
    // R2: stopped select holds counter
    repeat (20) @(posedge clk);
    do_read(3'd2, "R2 stopped low");
    chk("R2 stopped value", int'(rdata), 0);
    // R8: reload bytes
    do_write(3'd3, 8'hFF);
    do_write(3'd4, 8'hF0);
    do_read(3'd3, "R8 reload hi");
    do_read(3'd4, "R8 reload lo");
    // R3/R4: cpu enable, overflow enable, compare enable
    do_write(3'd0, 8'b0001_0011);
    do_read(3'd0, "R5 ctrl readback");
    repeat (30) @(posedge clk);
    do_read(3'd2, "R3 cpu rate low");
    do_read(3'd1, "R7 count hi");
    // R7: writes to counter ignored
    do_write(3'd2, 8'h55);
    do_write(3'd1, 8'h0A);
    do_read(3'd2, "R7 write ignored low");
    do_read(3'd1, "R7 write ignored hi");
    repeat (8400) @(posedge clk);
    chk("R4 overflow seen", int'(ovf_irq), 1);
    do_read(3'd2, "R4 reloaded low");
    do_read(3'd0, "R5 ctrl with flag");
    do_read(3'd0, "R5 flag cleared");
    // R6: write with flag positions set
    do_write(3'd0, 8'b1100_0111);
    do_read(3'd0, "R6 ctrl after write");
    // R9: captures while counting
    do_write(3'd0, 8'b0011_0010);
    pulse_pin(4);
    repeat (3) @(posedge clk);
    chk("R9 cap irq", int'(cap_irq), 1);
    do_read(3'd5, "R9 capture hi");
    do_read(3'd6, "R9 capture lo");
    do_read(3'd0, "R10 flag after read");
    pulse_pin(1);
    repeat (5) @(posedge clk);
    do_read(3'd6, "R9 capture lo 2");
    do_read(3'd0, "R10 cleared by low");
    // R3: timebase select
    do_write(3'd0, 8'b0000_1010);
    repeat (40) @(posedge clk);
    do_read(3'd2, "R3 base rate low");
    // R5/R10: frequent wraps against back-to-back reads
    do_write(3'd4, 8'hFE);
    do_write(3'd0, 8'b0011_1010);
    for (int i = 0; i < 40; i++) begin
      do_read(3'd0, "R5 set wins");
      if (i % 5 == 0) pulse_pin(1);
      do_read(3'(5 + (i % 2)), "R10 set wins");
    end
    do_read(3'd2, "R2 final low");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule